// File: doc/BRIEF.md
# Debug bus visibility controller

This block sits between a small microcontroller core and the external multiplexed bus and gives a logic analyser two views of what the core is doing. First, an active-low instruction strobe goes low for the bus cycle in which the core fetches the opcode of a new instruction. With that marker, a captured trace can be split into instructions and disassembled.

Second, a read-visibility control bit decides whether the data of reads from internal registers or memory is copied onto the external data bus. Normally nothing drives the external bus on such reads. The visibility bit's value after reset depends on the operating mode latched during reset. Its write rules are one-way: once software has cleared it, it stays cleared until the next reset. Whether normal modes may switch it on is set by a derivative parameter.

Inputs come from the core: the opcode-fetch and internal-read indications, the read/write direction, the internal read data, and a one-bit write port for the control bit. The mode pins and a synchronous active-low reset complete the inputs. With the default parameters all bus-facing outputs are registered, so they follow their inputs one clock later.

Top module: `dbg_vis_ctrl`

## Requirements
- R1: The mode pins are encoded as 00 bootstrap, 01 test, 10 single-chip and 11 expanded. The first two are special modes and the last two are normal modes. During reset the visibility bit is loaded with 1 for a special mode and with 0 for a normal mode, and `cfg_rbit_o` shows it from that point on.
- R2: The operating mode is sampled only while `rst_n` is low. Changes on `mode_i` after reset has been released do not alter the write rules until the next reset.
- R3: `instr_strobe_n_o` is low in the cycle after `fetch_i` was sampled high, and high in every other cycle, including during reset.
- R4: When the visibility bit is 1 and a cycle is sampled with `int_rd_i`=1 and `rw_i`=1 (read), the next cycle has `bus_drv_en_o`=1 and `bus_data_o` equal to the sampled `int_data_i`.
- R5: When the visibility bit is 0, `bus_drv_en_o` stays 0 and `bus_data_o` stays 0 for internal reads.
- R6: `bus_drv_en_o` is 0 after any cycle with `int_rd_i`=0 or `rw_i`=0, whatever the visibility bit holds.
- R7: A write of 0 clears the visibility bit in every mode and sets a sticky lock. While the lock is set, every write of 1 is ignored.
- R8: With `DERIV_NEW`=0, a write of 1 while the latched mode is normal is ignored.
- R9: With `DERIV_NEW`=1, a write of 1 in a normal mode sets the bit, provided it has not been written to 0 since reset.
- R10: A write changes the bit at the clock edge that captures it. An internal read in the same cycle as the write is judged against the value held before that write.
- R11: Reset clears the lock, so the bit once again follows the R1 and R9 rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Mode pins, sampled during reset |
| cfg_we_i | input | 1 | Write strobe for the visibility bit |
| cfg_wbit_i | input | 1 | Value written to the visibility bit |
| fetch_i | input | 1 | Core fetches the opcode of a new instruction this cycle |
| int_rd_i | input | 1 | Current cycle addresses an internal register or memory |
| rw_i | input | 1 | Bus direction, 1 = read, 0 = write |
| int_data_i | input | DATA_W | Data returned by the internal read |
| bus_drv_en_o | output | 1 | Drive enable for the external data pads |
| bus_data_o | output | DATA_W | Data placed on the external bus, 0 when not driving |
| instr_strobe_n_o | output | 1 | Active-low first-cycle-of-instruction strobe |
| cfg_rbit_o | output | 1 | Current value of the visibility bit |

## Verification
The collision that matters is a write to the visibility bit in the same cycle as an internal read. The bench provokes it directly: a write of 0 lands together with an internal read while the bit is 1. It then expects the bus to be driven for that read and left quiet for the read that follows. The random phase also mixes writes, reads and fetch cycles freely, and a bench model that updates the bit only after judging the cycle's read checks every such overlap. Two instances, one for each derivative setting, share the stimulus, so one run covers both sets of write rules.

// File: rtl/dbg_vis_pkg.sv
package dbg_vis_pkg;

   typedef enum logic [1:0] {
      MODE_BOOT   = 2'b00,
      MODE_TEST   = 2'b01,
      MODE_SINGLE = 2'b10,
      MODE_EXPAND = 2'b11
   } op_mode_e;

   function automatic logic mode_is_special(input logic [1:0] m);
      return (m == MODE_BOOT) || (m == MODE_TEST);
   endfunction

endpackage

// File: rtl/dbg_mode_latch.sv
module dbg_mode_latch
   import dbg_vis_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   output logic       special_o
);
   logic special_q;

   always_ff @(posedge clk) begin
      if (!rst_n) special_q <= mode_is_special(mode_i);
   end

   assign special_o = special_q;

   // R2: latched mode is frozen once reset has been released
   p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(special_q));

endmodule

// File: rtl/dbg_vis_reg.sv
module dbg_vis_reg
   import dbg_vis_pkg::*;
#(
   parameter bit DERIV_NEW = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic rst_special_i,
   input  logic special_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic vis_o
);
   logic vis_q;
   logic lock_q;
   logic set_perm;
   logic set_ok;

   generate
      if (DERIV_NEW) begin : g_new
         assign set_perm = 1'b1;
      end else begin : g_old
         assign set_perm = special_i;
         // R8: older derivative never turns the bit on in a normal mode
         p_old_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!special_i && !vis_q) |=> !vis_q);
      end
   endgenerate

   assign set_ok = !lock_q && set_perm;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vis_q  <= rst_special_i;
         lock_q <= 1'b0;
      end else if (wr_i) begin
         if (!wbit_i) begin
            vis_q  <= 1'b0;
            lock_q <= 1'b1;
         end else if (set_ok) begin
            vis_q  <= 1'b1;
         end
      end
   end

   assign vis_o = vis_q;

   // R7: locked means off, and the lock never falls outside reset
   p_lock_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> !vis_q);
   p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
   // R7: a zero write always lands
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wbit_i) |=> !vis_o);
   // R9: permitted set lands
   p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wbit_i && !lock_q && set_perm) |=> vis_o);

endmodule

// File: rtl/dbg_bus_drive.sv
module dbg_bus_drive #(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vis_i,
   input  logic              int_rd_i,
   input  logic              rw_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              drv_en_o,
   output logic [DATA_W-1:0] data_o
);
   logic              drv_c;
   logic [DATA_W-1:0] data_c;

   always_comb begin
      drv_c  = rst_n && vis_i && int_rd_i && rw_i;
      data_c = drv_c ? data_i : '0;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic              drv_q;
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               drv_q  <= 1'b0;
               data_q <= '0;
            end else begin
               drv_q  <= drv_c;
               data_q <= data_c;
            end
         end
         assign drv_en_o = drv_q;
         assign data_o   = data_q;

         // R4: visible internal read shows up next cycle with its data
         p_drive_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (vis_i && int_rd_i && rw_i) |=> (drv_en_o && data_o == $past(data_i)));
         // R5: bit off means quiet bus
         p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !vis_i |=> (!drv_en_o && data_o == '0));
         // R6: no drive after external or write cycles
         p_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!int_rd_i || !rw_i) |=> !drv_en_o);
      end else begin : g_comb
         assign drv_en_o = drv_c;
         assign data_o   = data_c;
      end
   endgenerate

endmodule

// File: rtl/dbg_fetch_strobe.sv
module dbg_fetch_strobe #(
   parameter bit REG_OUT = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic fetch_i,
   output logic strobe_n_o
);
   generate
      if (REG_OUT) begin : g_reg
         logic strobe_n_q;
         always_ff @(posedge clk) begin
            if (!rst_n) strobe_n_q <= 1'b1;
            else        strobe_n_q <= !fetch_i;
         end
         assign strobe_n_o = strobe_n_q;

         // R3: low exactly in the cycle after an opcode fetch
         p_strobe_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_i |=> !strobe_n_o);
         p_strobe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !fetch_i |=> strobe_n_o);
      end else begin : g_comb
         assign strobe_n_o = !(rst_n && fetch_i);
      end
   endgenerate

endmodule

// File: rtl/dbg_vis_ctrl.sv
module dbg_vis_ctrl
   import dbg_vis_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit REG_OUT   = 1'b1,
   parameter bit DERIV_NEW = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              cfg_we_i,
   input  logic              cfg_wbit_i,
   input  logic              fetch_i,
   input  logic              int_rd_i,
   input  logic              rw_i,
   input  logic [DATA_W-1:0] int_data_i,
   output logic              bus_drv_en_o,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              instr_strobe_n_o,
   output logic              cfg_rbit_o
);
   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
         $error("dbg_vis_ctrl: DATA_W must lie in 1..64");
      end
   endgenerate

   logic special;
   logic vis;

   dbg_mode_latch u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode_i),
      .special_o (special)
   );

   dbg_vis_reg #(.DERIV_NEW(DERIV_NEW)) u_vis (
      .clk           (clk),
      .rst_n         (rst_n),
      .rst_special_i (mode_is_special(mode_i)),
      .special_i     (special),
      .wr_i          (cfg_we_i),
      .wbit_i        (cfg_wbit_i),
      .vis_o         (vis)
   );

   dbg_bus_drive #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .vis_i    (vis),
      .int_rd_i (int_rd_i),
      .rw_i     (rw_i),
      .data_i   (int_data_i),
      .drv_en_o (bus_drv_en_o),
      .data_o   (bus_data_o)
   );

   dbg_fetch_strobe #(.REG_OUT(REG_OUT)) u_strobe (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_i    (fetch_i),
      .strobe_n_o (instr_strobe_n_o)
   );

   assign cfg_rbit_o = vis;

   // R1: reset value tracks the mode pins seen during reset
   p_reset_val_r1: assert property (@(posedge clk)
      !rst_n |=> (cfg_rbit_o == mode_is_special($past(mode_i))));

endmodule

// File: tb/test_dbg_vis_ctrl.sv
module test_dbg_vis_ctrl;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_i = 2'b10;
   logic          cfg_we_i = 1'b0, cfg_wbit_i = 1'b0;
   logic          fetch_i = 1'b0, int_rd_i = 1'b0, rw_i = 1'b1;
   logic [DW-1:0] int_data_i = '0;

   logic          drv_n, strb_n, rbit_n;
   logic [DW-1:0] data_n;
   logic          drv_o, strb_o, rbit_o;
   logic [DW-1:0] data_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic m_special, m_vis_n, m_lock_n, m_vis_o, m_lock_o;

   always #10 clk = ~clk;   // 50 MHz

   dbg_vis_ctrl #(.DATA_W(DW), .REG_OUT(1'b1), .DERIV_NEW(1'b1)) i_dbg_vis_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_we_i(cfg_we_i), .cfg_wbit_i(cfg_wbit_i),
      .fetch_i(fetch_i), .int_rd_i(int_rd_i), .rw_i(rw_i), .int_data_i(int_data_i),
      .bus_drv_en_o(drv_n), .bus_data_o(data_n), .instr_strobe_n_o(strb_n), .cfg_rbit_o(rbit_n));

   dbg_vis_ctrl #(.DATA_W(DW), .REG_OUT(1'b1), .DERIV_NEW(1'b0)) i_dbg_vis_ctrl_old (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_we_i(cfg_we_i), .cfg_wbit_i(cfg_wbit_i),
      .fetch_i(fetch_i), .int_rd_i(int_rd_i), .rw_i(rw_i), .int_data_i(int_data_i),
      .bus_drv_en_o(drv_o), .bus_data_o(data_o), .instr_strobe_n_o(strb_o), .cfg_rbit_o(rbit_o));

   function automatic logic f_special(input logic [1:0] m);
      return (m == 2'b00) || (m == 2'b01);
   endfunction

   function automatic logic f_next_vis(input logic vis, input logic lock, input logic special,
                                       input bit newer, input logic we, input logic wb);
      if (!we) return vis;
      if (!wb) return 1'b0;
      if (!lock && (special || newer)) return 1'b1;
      return vis;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One bus cycle: drive at negedge, capture at posedge, judge at next negedge.
   task automatic cyc(input logic we, input logic wb, input logic fe,
                      input logic ird, input logic rw, input logic [DW-1:0] d);
      logic e_drv_n, e_drv_o;
      string dtag;
      e_drv_n = m_vis_n && ird && rw;
      e_drv_o = m_vis_o && ird && rw;
      dtag = (!(ird && rw)) ? "R6" : (m_vis_n ? "R4" : "R5");
      cfg_we_i = we; cfg_wbit_i = wb; fetch_i = fe; int_rd_i = ird; rw_i = rw; int_data_i = d;
      @(posedge clk);
      m_vis_n  = f_next_vis(m_vis_n, m_lock_n, m_special, 1'b1, we, wb);
      m_vis_o  = f_next_vis(m_vis_o, m_lock_o, m_special, 1'b0, we, wb);
      m_lock_n = m_lock_n | (we & ~wb);
      m_lock_o = m_lock_o | (we & ~wb);
      @(negedge clk);
      chk("R3 strobe", int'(strb_n), int'(!fe));
      chk({dtag, " drive"}, int'(drv_n), int'(e_drv_n));
      chk("R4 data", int'(data_n), e_drv_n ? int'(d) : 0);
      chk({(e_drv_o ? "R4" : "R6"), " drive old"}, int'(drv_o), int'(e_drv_o));
      chk(m_lock_n ? "R7 rbit" : "R9 rbit", int'(rbit_n), int'(m_vis_n));
      chk("R8 rbit old", int'(rbit_o), int'(m_vis_o));
   endtask

   task automatic do_reset(input logic [1:0] md);
      rst_n = 1'b0; mode_i = md;
      cfg_we_i = 1'b0; fetch_i = 1'b1; int_rd_i = 1'b1; rw_i = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R3 strobe in reset", int'(strb_n), 1);
      chk("R6 drive in reset", int'(drv_n), 0);
      rst_n = 1'b1; fetch_i = 1'b0; int_rd_i = 1'b0;
      m_special = f_special(md);
      m_vis_n = m_special; m_vis_o = m_special;
      m_lock_n = 1'b0; m_lock_o = 1'b0;
      chk("R1 reset value", int'(rbit_n), int'(m_special));
      chk("R1 reset value old", int'(rbit_o), int'(m_special));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      // Normal mode reset: bit off (R1), reads stay quiet (R5), strobe (R3)
      do_reset(2'b10);
      cyc(0, 0, 0, 1, 1, 8'hA5);
      cyc(0, 0, 1, 0, 1, 8'h00);
      // Pins move to a special code after reset; rules must not change (R2)
      mode_i = 2'b00;
      cyc(1, 1, 0, 0, 1, 8'h00);
      chk("R9 set in normal mode", int'(rbit_n), 1);
      chk("R2 latched normal mode, old ignores set", int'(rbit_o), 0);
      // Visible internal read (R4), then external and write cycles (R6)
      cyc(0, 0, 0, 1, 1, 8'h3C);
      cyc(0, 0, 0, 0, 1, 8'h77);
      cyc(0, 0, 0, 1, 0, 8'h77);
      // Same-cycle clear and read: read uses old value (R10)
      cyc(1, 0, 0, 1, 1, 8'hC3);
      chk("R10 same-cycle read driven", int'(drv_n), 1);
      cyc(0, 0, 0, 1, 1, 8'h5A);
      chk("R10 following read quiet", int'(drv_n), 0);
      // Lock holds against writes of one (R7)
      cyc(1, 1, 0, 0, 1, 8'h00);
      chk("R7 locked bit stays zero", int'(rbit_n), 0);
      // Special mode: on at reset, clear locks (R1, R7), reset unlocks (R11)
      do_reset(2'b01);
      cyc(1, 1, 0, 1, 1, 8'h11);
      chk("R7 special write one keeps bit", int'(rbit_o), 1);
      cyc(1, 0, 0, 1, 1, 8'h22);
      cyc(1, 1, 0, 1, 1, 8'h33);
      chk("R7 special locked", int'(rbit_o), 0);
      do_reset(2'b11);
      cyc(1, 1, 0, 0, 1, 8'h00);
      chk("R11 reset cleared lock", int'(rbit_n), 1);
      chk("R8 old ignores normal set", int'(rbit_o), 0);

      // Constrained random phase
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 249) == 0) begin
            do_reset(2'($urandom_range(0, 3)));
         end else begin
            if ($urandom_range(0, 15) == 0) mode_i = 2'($urandom_range(0, 3));
            cyc(($urandom_range(0, 9) == 0), ($urandom_range(0, 3) != 0),
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1),
                ($urandom_range(0, 4) != 0), DW'($urandom));
         end
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule